// File: doc/BRIEF.md
# Serial Port Interrupt Mask and Sticky Status Unit

This block keeps the interrupt state of a serial port controller with thirteen event sources. Software never rewrites the mask directly. One write port turns mask bits on and a second write port turns mask bits off. The mask can be read back but not written. The event sources arrive as single-cycle pulses from the transmit and receive logic. Each pulse latches a sticky status bit, and only a write of one to that bit clears it. The single interrupt line is high whenever a status bit is set and its mask bit is on.

A modem-line section sits next to the status logic. It brings the four asynchronous handshake inputs into the clock domain through a synchronizer of configurable depth. It records each change in its own sticky delta bit, which is also cleared by writing one. A delta bit that goes from clear to set raises the shared modem-change status source. That source is produced inside the block, so the external pulse on its input lane is ignored.

Top module: `sio_irq_unit`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the mask, status and delta registers read zero and irq_o is low.
- R2: A cycle with ena_wr high sets every mask bit whose ena_bits bit is 1. Mask bits whose ena_bits bit is 0 keep their value. The new mask is visible after that clock edge.
- R3: A cycle with dis_wr high clears every mask bit whose dis_bits bit is 1. When the same bit is enabled and disabled in the same cycle, the disable takes effect and the bit ends clear.
- R4: A pulse on src_evt bit i sets status bit i on the next edge, whether or not the bit is masked. Source positions: 0 rx trigger, 1 rx empty, 2 rx full, 3 tx empty, 4 tx full, 5 rx overflow, 6 framing, 7 parity, 8 rx timeout, 9 modem change, 10 tx trigger, 11 tx nearly full, 12 tx overflow. A status bit stays set until it is cleared.
- R5: A cycle with sts_clr_wr high clears each status bit whose sts_clr_bits bit is 1. Bits written with 0 are unchanged.
- R6: When an event and a clear hit the same status bit in the same cycle, the event wins and the bit remains set.
- R7: irq_o is high exactly when some bit of (status AND mask) is 1. Enabling a bit that is already set raises irq_o right away.
- R8: src_evt bit 9 has no effect. Status bit 9 is set only by the modem section.
- R9: Delta bits are 0 CTS change, 1 DSR change, 2 ring trailing edge, 3 DCD change. A level change on CTS, DSR or DCD sets its delta bit SYNC_STAGES+1 clock edges after the input changes, and not earlier.
- R10: The ring delta bit sets only when the synchronized ring line falls. A rising ring line sets nothing.
- R11: A cycle with mdm_clr_wr high clears each delta bit whose mdm_clr_bits bit is 1, and bits written with 0 stay set. A change detected in that same cycle wins over the clear.
- R12: Status bit 9 is set in the same cycle that any delta bit goes from 0 to 1. A change on a line whose delta bit is already set does not raise it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ena_wr | input | 1 | Write strobe of the mask-set port |
| ena_bits | input | 13 | Ones select mask bits to set |
| dis_wr | input | 1 | Write strobe of the mask-clear port |
| dis_bits | input | 13 | Ones select mask bits to clear |
| sts_clr_wr | input | 1 | Write strobe of the status clear port |
| sts_clr_bits | input | 13 | Ones select status bits to clear |
| src_evt | input | 13 | Event pulses, one lane per source |
| mdm_line | input | 4 | Raw modem lines: CTS, DSR, ring, DCD |
| mdm_clr_wr | input | 1 | Write strobe of the delta clear port |
| mdm_clr_bits | input | 4 | Ones select delta bits to clear |
| mask_o | output | 13 | Current interrupt mask |
| status_o | output | 13 | Sticky status bits |
| delta_o | output | 4 | Sticky modem delta bits |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the unit with SYNC_STAGES set to 3 rather than the default 2. This shows that the modem latency follows the parameter, and the bench checks the delta bit both one edge before and at the edge where it should appear. The deeper chain also makes room for a delta clear placed in exactly the cycle a change is detected, which tests the rule that set wins over clear. The thirteen-bit source width is fixed, so every source lane, including the ignored modem lane, is driven at its real position.

// File: rtl/sio_irq_pkg.sv
// Shared widths and bit positions for the serial interrupt unit.
package sio_irq_pkg;
    localparam int SRC_COUNT   = 13;
    localparam int MDM_LINES   = 4;

    // Source positions (software decodes these)
    localparam int SRC_RX_TRIG  = 0;
    localparam int SRC_RX_EMPTY = 1;
    localparam int SRC_RX_FULL  = 2;
    localparam int SRC_TX_EMPTY = 3;
    localparam int SRC_TX_FULL  = 4;
    localparam int SRC_RX_OVR   = 5;
    localparam int SRC_FRAMING  = 6;
    localparam int SRC_PARITY   = 7;
    localparam int SRC_RX_TMO   = 8;
    localparam int SRC_MODEM    = 9;
    localparam int SRC_TX_TRIG  = 10;
    localparam int SRC_TX_NFULL = 11;
    localparam int SRC_TX_OVR   = 12;

    // Modem line / delta positions
    localparam int MDM_CTS = 0;
    localparam int MDM_DSR = 1;
    localparam int MDM_RI  = 2;
    localparam int MDM_DCD = 3;

    typedef logic [SRC_COUNT-1:0] src_vec_t;
    typedef logic [MDM_LINES-1:0] mdm_vec_t;
endpackage

// File: rtl/sio_irq_mask.sv
// Interrupt mask held behind separate set and clear write ports.
// Assumes both ports may strobe in one cycle; clearing takes priority.
module sio_irq_mask #(
    parameter int WIDTH = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_wr,
    input  logic [WIDTH-1:0] set_bits,
    input  logic             clr_wr,
    input  logic [WIDTH-1:0] clr_bits,
    output logic [WIDTH-1:0] mask_q
);
    logic [WIDTH-1:0] set_eff;
    logic [WIDTH-1:0] clr_eff;

    // Qualify the write data with its strobe.
    always_comb begin
        set_eff = set_wr ? set_bits : '0;
        clr_eff = clr_wr ? clr_bits : '0;
    end

    // Apply set first, then clear, so clear wins on a shared bit.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= (mask_q | set_eff) & ~clr_eff;
    end

    // R2: enabled bits are on after the write unless also disabled
    a_r2_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> ((mask_q & $past(set_bits & ~clr_eff)) == $past(set_bits & ~clr_eff)));
    // R3: disabled bits are off after the write
    a_r3_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((mask_q & $past(clr_bits)) == '0));
    // R2: mask holds with no write
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_wr && !clr_wr) |=> $stable(mask_q));
endmodule

// File: rtl/sio_irq_status.sv
// Sticky status bits: set by event pulses, cleared by writing ones.
// Assumes events are single-cycle pulses; an event beats a same-cycle clear.
module sio_irq_status #(
    parameter int WIDTH = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] evt,
    input  logic             clr_wr,
    input  logic [WIDTH-1:0] clr_bits,
    output logic [WIDTH-1:0] status_q
);
    logic [WIDTH-1:0] clr_eff;

    // Qualify the clear mask with its strobe.
    always_comb clr_eff = clr_wr ? clr_bits : '0;

    // Clear the written ones, then OR in new events so events win.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_eff) | evt;
    end

    // R4 / R6: every pulsed bit is set on the next edge, clear or not
    a_r4_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(evt)) == $past(evt)));
    // R4: without a clear no set bit falls
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((status_q & $past(status_q)) == $past(status_q)));
    // R5: cleared bits without a competing event go to zero
    a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((status_q & $past(clr_bits & ~evt)) == '0));
endmodule

// File: rtl/sio_modem_delta.sv
// Modem line change tracker: synchronizes raw lines, keeps sticky
// per-line change bits (ring: falling edge only) and emits a pulse when
// any change bit goes from clear to set. Assumes lines are asynchronous.
module sio_modem_delta #(
    parameter int LINES       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int RING_IDX    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] line_in,
    input  logic             clr_wr,
    input  logic [LINES-1:0] clr_bits,
    output logic [LINES-1:0] delta_q,
    output logic             raise_evt
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LINES-1:0] sync_q [SYNC_STAGES];
    logic [LINES-1:0] prev_q;
    logic [LINES-1:0] cur;
    logic [LINES-1:0] change;
    logic [LINES-1:0] clr_eff;

    // Synchronizer chain into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
        end else begin
            sync_q[0] <= line_in;
            for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
        end
    end

    assign cur = sync_q[LAST];

    // Remember the last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= cur;
    end

    // Per-line edge policy: ring line reports trailing edge only.
    for (genvar g = 0; g < LINES; g++) begin : g_edge
        if (g == RING_IDX) begin : g_fall
            assign change[g] = prev_q[g] & ~cur[g];
        end else begin : g_any
            assign change[g] = prev_q[g] ^ cur[g];
        end
    end

    // Qualify the delta clear with its strobe.
    always_comb clr_eff = clr_wr ? clr_bits : '0;

    // Sticky delta bits with set-wins-over-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) delta_q <= '0;
        else        delta_q <= (delta_q & ~clr_eff) | change;
    end

    // Summary source: a delta bit newly becoming set.
    assign raise_evt = |(change & ~delta_q);

    // R10: ring delta only rises after a synchronized falling ring level
    a_r10_ring_trailing: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(delta_q[RING_IDX]) |-> ($past(prev_q[RING_IDX]) && !$past(cur[RING_IDX])));
    // R11: without a clear, delta bits never fall
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((delta_q & $past(delta_q)) == $past(delta_q)));
    // R11: a clear with no competing change empties the bit
    a_r11_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((delta_q & $past(clr_bits & ~change)) == '0));
    // R12: any newly set delta bit coincides with a summary pulse
    a_r12_new_delta_raises: assert property (@(posedge clk) disable iff (!rst_n)
        ((delta_q & ~$past(delta_q)) != '0) |-> $past(raise_evt));
endmodule

// File: rtl/sio_irq_unit.sv
// Top of the serial interrupt unit: mask with set/clear ports, sticky
// status, modem delta section feeding the modem-change source, and the
// single interrupt request. Assumes all write strobes are one cycle wide.
module sio_irq_unit
    import sio_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ena_wr,
    input  logic [SRC_COUNT-1:0] ena_bits,
    input  logic                 dis_wr,
    input  logic [SRC_COUNT-1:0] dis_bits,
    input  logic                 sts_clr_wr,
    input  logic [SRC_COUNT-1:0] sts_clr_bits,
    input  logic [SRC_COUNT-1:0] src_evt,
    input  logic [MDM_LINES-1:0] mdm_line,
    input  logic                 mdm_clr_wr,
    input  logic [MDM_LINES-1:0] mdm_clr_bits,
    output logic [SRC_COUNT-1:0] mask_o,
    output logic [SRC_COUNT-1:0] status_o,
    output logic [MDM_LINES-1:0] delta_o,
    output logic                 irq_o
);
    src_vec_t mask_q;
    src_vec_t status_q;
    src_vec_t evt_merged;
    mdm_vec_t delta_q;
    logic     mdm_evt;

    sio_irq_mask #(.WIDTH(SRC_COUNT)) mask_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_wr   (ena_wr),
        .set_bits (ena_bits),
        .clr_wr   (dis_wr),
        .clr_bits (dis_bits),
        .mask_q   (mask_q)
    );

    sio_modem_delta #(
        .LINES       (MDM_LINES),
        .SYNC_STAGES (SYNC_STAGES),
        .RING_IDX    (MDM_RI)
    ) delta_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (mdm_line),
        .clr_wr    (mdm_clr_wr),
        .clr_bits  (mdm_clr_bits),
        .delta_q   (delta_q),
        .raise_evt (mdm_evt)
    );

    // Route external pulses, replacing the modem lane with the internal one.
    for (genvar g = 0; g < SRC_COUNT; g++) begin : g_evt
        if (g == SRC_MODEM) begin : g_mdm
            assign evt_merged[g] = mdm_evt;
        end else begin : g_ext
            assign evt_merged[g] = src_evt[g];
        end
    end

    sio_irq_status #(.WIDTH(SRC_COUNT)) status_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_merged),
        .clr_wr   (sts_clr_wr),
        .clr_bits (sts_clr_bits),
        .status_q (status_q)
    );

    // Interrupt request from enabled pending sources.
    always_comb irq_o = |(status_q & mask_q);

    assign mask_o   = mask_q;
    assign status_o = status_q;
    assign delta_o  = delta_q;

    // R8: the external modem lane alone never sets status bit 9
    a_r8_ext_modem_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (src_evt[SRC_MODEM] && !mdm_evt && !status_q[SRC_MODEM]) |=> !status_q[SRC_MODEM]);
    // R12: a modem summary pulse always lands in status bit 9
    a_r12_summary_lands: assert property (@(posedge clk) disable iff (!rst_n)
        mdm_evt |=> status_q[SRC_MODEM]);
endmodule

// File: tb/sio_irq_unit_tb_top.sv
// Directed bench for the serial interrupt unit.
module sio_irq_unit_tb_top;
    import sio_irq_pkg::*;

    localparam int NSYNC = 3;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 ena_wr = 1'b0, dis_wr = 1'b0, sts_clr_wr = 1'b0, mdm_clr_wr = 1'b0;
    logic [SRC_COUNT-1:0] ena_bits = '0, dis_bits = '0, sts_clr_bits = '0, src_evt = '0;
    logic [MDM_LINES-1:0] mdm_line = '0, mdm_clr_bits = '0;
    logic [SRC_COUNT-1:0] mask_o, status_o;
    logic [MDM_LINES-1:0] delta_o;
    logic                 irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sio_irq_unit #(.SYNC_STAGES(NSYNC)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .ena_wr(ena_wr), .ena_bits(ena_bits),
        .dis_wr(dis_wr), .dis_bits(dis_bits),
        .sts_clr_wr(sts_clr_wr), .sts_clr_bits(sts_clr_bits),
        .src_evt(src_evt), .mdm_line(mdm_line),
        .mdm_clr_wr(mdm_clr_wr), .mdm_clr_bits(mdm_clr_bits),
        .mask_o(mask_o), .status_o(status_o), .delta_o(delta_o), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One-cycle strobes, driven on the falling edge; results sampled one cycle later.
    task automatic strobe(input logic [SRC_COUNT-1:0] en, input logic [SRC_COUNT-1:0] dis,
                          input logic [SRC_COUNT-1:0] clr, input logic [SRC_COUNT-1:0] ev,
                          input logic [MDM_LINES-1:0] dclr);
        @(negedge clk);
        ena_wr = (en != '0);  ena_bits = en;
        dis_wr = (dis != '0); dis_bits = dis;
        sts_clr_wr = (clr != '0); sts_clr_bits = clr;
        src_evt = ev;
        mdm_clr_wr = (dclr != '0); mdm_clr_bits = dclr;
        @(negedge clk);
        ena_wr = 1'b0; dis_wr = 1'b0; sts_clr_wr = 1'b0; mdm_clr_wr = 1'b0;
        ena_bits = '0; dis_bits = '0; sts_clr_bits = '0; src_evt = '0; mdm_clr_bits = '0;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 mask", 16'(mask_o), 16'h0);
        chk("R1 status", 16'(status_o), 16'h0);
        chk("R1 delta", 16'(delta_o), 16'h0);
        chk("R1 irq", 16'(irq_o), 16'h0);
    endtask

    task automatic t_mask;
        strobe(13'h00A5, '0, '0, '0, '0);
        chk("R2 enable first", 16'(mask_o), 16'h00A5);
        strobe(13'h0100, '0, '0, '0, '0);
        chk("R2 enable keeps others", 16'(mask_o), 16'h01A5);
        strobe('0, 13'h0005, '0, '0, '0);
        chk("R3 disable", 16'(mask_o), 16'h01A0);
        strobe(13'h0003, 13'h0001, '0, '0, '0);
        chk("R3 disable wins", 16'(mask_o), 16'h01A2);
        strobe('0, 13'h1FFF, '0, '0, '0);
        chk("R3 disable all", 16'(mask_o), 16'h0);
    endtask

    task automatic t_status;
        strobe('0, '0, '0, 13'h1001, '0);
        chk("R4 latch bits 0,12", 16'(status_o), 16'h1001);
        chk("R7 masked no irq", 16'(irq_o), 16'h0);
        wait_cycles(3);
        chk("R4 sticky", 16'(status_o), 16'h1001);
        strobe('0, '0, 13'h0000, '0, '0);
        @(negedge clk); sts_clr_wr = 1'b1; sts_clr_bits = '0;
        @(negedge clk); sts_clr_wr = 1'b0;
        chk("R5 zero write no effect", 16'(status_o), 16'h1001);
        strobe('0, '0, 13'h0001, '0, '0);
        chk("R5 w1c bit0", 16'(status_o), 16'h1000);
        strobe(13'h1000, '0, '0, '0, '0);
        chk("R7 enable pending raises irq", 16'(irq_o), 16'h1);
        strobe('0, '0, 13'h1000, '0, '0);
        chk("R7 cleared drops irq", 16'(irq_o), 16'h0);
        chk("R5 status empty", 16'(status_o), 16'h0);
        strobe('0, 13'h1000, '0, '0, '0);
    endtask

    task automatic t_race;
        strobe('0, '0, 13'h0040, 13'h0040, '0);
        chk("R6 event beats clear", 16'(status_o), 16'h0040);
        strobe('0, '0, 13'h0040, '0, '0);
        chk("R6 later clear", 16'(status_o), 16'h0);
    endtask

    task automatic t_ignore;
        strobe('0, '0, '0, 13'h0200, '0);
        wait_cycles(2);
        chk("R8 ext modem lane ignored", 16'(status_o), 16'h0);
    endtask

    task automatic t_modem;
        @(negedge clk); mdm_line[MDM_CTS] = 1'b1;
        wait_cycles(NSYNC);
        chk("R9 not before latency", 16'(delta_o), 16'h0);
        @(negedge clk);
        chk("R9 cts change", 16'(delta_o), 16'h1);
        chk("R12 modem source raised", 16'(status_o), 16'h0200);
        strobe('0, '0, 13'h0200, '0, '0);
        @(negedge clk); mdm_line[MDM_CTS] = 1'b0;
        wait_cycles(NSYNC + 2);
        chk("R12 no re-raise", 16'(status_o), 16'h0);
        chk("R9 cts still set", 16'(delta_o), 16'h1);
        strobe('0, '0, '0, '0, 4'h1);
        chk("R11 delta w1c", 16'(delta_o), 16'h0);
        @(negedge clk); mdm_line[MDM_RI] = 1'b1;
        wait_cycles(NSYNC + 3);
        chk("R10 ring rise ignored", 16'(delta_o), 16'h0);
        chk("R10 ring rise no source", 16'(status_o), 16'h0);
        @(negedge clk); mdm_line[MDM_RI] = 1'b0;
        wait_cycles(NSYNC + 1);
        chk("R10 ring trailing edge", 16'(delta_o), 16'h4);
        chk("R12 ring raises source", 16'(status_o), 16'h0200);
        @(negedge clk); mdm_line[MDM_DCD] = 1'b1;
        wait_cycles(NSYNC + 1);
        chk("R9 dcd change", 16'(delta_o), 16'hC);
        strobe('0, '0, '0, '0, 4'h0);
        @(negedge clk); mdm_clr_wr = 1'b1; mdm_clr_bits = '0;
        @(negedge clk); mdm_clr_wr = 1'b0;
        chk("R11 zero write keeps delta", 16'(delta_o), 16'hC);
        // Clear lands in the exact cycle the DSR change is detected.
        @(negedge clk); mdm_line[MDM_DSR] = 1'b1;
        wait_cycles(NSYNC);
        mdm_clr_wr = 1'b1; mdm_clr_bits = 4'h2;
        @(negedge clk); mdm_clr_wr = 1'b0; mdm_clr_bits = '0;
        chk("R11 change beats clear", 16'(delta_o), 16'hE);
        strobe('0, '0, 13'h0200, '0, 4'hF);
        chk("R11 clear all", 16'(delta_o), 16'h0);
    endtask

    initial begin
        wait_cycles(3);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_mask();
        t_status();
        t_race();
        t_ignore();
        t_modem();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule